// File: doc/BRIEF.md
# Bisection Threshold Search Controller

This block finds a scalar threshold by bisection, driving an external solver that it does not contain. For every tentative threshold it pulses a launch line, holds the tentative value steady on its output, and waits for the solver's completion pulse. The completion pulse carries two flags: whether the constraint residual is negative and whether it is exactly zero. The residual is assumed to rise monotonically with the threshold and to cross zero once.

The search has two phases. In the first, it finds a bracketing interval. It probes a low end that starts at -1.0 and a high end that starts at +1.0. While an end gives a residual of the wrong sign, it doubles that end. The number of doublings is capped. In the second phase it halves the bracket. It takes the floor of the mean of the two bounds as the next probe. It stops when the bracket becomes narrower than a programmable tolerance, or at once when a probe gives a zero residual. The threshold is a W-bit two's-complement fixed-point number with FRAC fraction bits, so with the defaults +1.0 is the raw value 16. The lines to the solver are plain control pins, not a stream. A launch is a single-cycle pulse, and the block ignores solve_done except while a probe is outstanding.

Top module: `thresh_bisect`

## Requirements
- R1: After reset, done, err and solve_go are 0 and thr_out is 0.
- R2: After start, the first probe is at raw -(1<<FRAC) (-16 by default). If that probe returns a negative residual, the next probe is at raw +(1<<FRAC).
- R3: If the low-end probe returns a positive residual, the low bound is doubled and probed again. If the high-end probe returns a negative residual, the high bound is doubled and probed again.
- R4: Doublings across both ends total at most MAX_EXP (8 by default). If a probe still gives the wrong sign when no doubling is left, the block ends the search with done=1 and err=1. err is never 1 while done is 0.
- R5: During bisection, each probe is floor((low+high)/2) of the current bounds. A positive residual makes that probe the new high bound. A negative residual makes it the new low bound.
- R6: Before each bisection probe, the search ends with done=1 and err=0 if (high-low), taken as an unsigned number, is below max(tol,2). thr_out then keeps the last probed value. No launch happens while done is 1.
- R7: A residual flagged as exactly zero ends the search at once, with done=1, err=0 and thr_out equal to that probe.
- R8: solve_go is a one-cycle pulse, with exactly one pulse per probe. It is never raised while a probe is outstanding, that is, between a launch and its solve_done.
- R9: thr_out holds the probed value without change from the launch until the matching solve_done.
- R10: done stays 1 until the next start. A start raised while a search is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a new search (honoured when idle or done) |
| tol | input | W | Unsigned bracket-width tolerance, raw fixed-point units |
| solve_go | output | 1 | One-cycle launch of the solver at thr_out |
| solve_done | input | 1 | Solver completion pulse, qualifies the residual flags |
| res_neg | input | 1 | Residual is negative |
| res_zero | input | 1 | Residual is exactly zero |
| thr_out | output | W | Current tentative threshold, two's complement |
| done | output | 1 | Search finished |
| err | output | 1 | Bracketing failed within the doubling limit |

## Verification
A solver stub computes the residual as the probe minus a hidden target. The bench compares the final threshold, the error flag and the number of launches with a reference search. Targets inside ±1.0 exercise plain bisection. Targets far above or below exercise doubling of the high or the low end. Targets beyond the expansion reach separate the error exit from a late bracket. Targets that coincide with a probe (the first probe, or the first midpoint) separate the zero-residual exit from the width exit. Sweeping the tolerance (0, 2, 4 and larger than the first bracket) and the solver latency (0 to 5 cycles) shows where the width test cuts in and that the handshake does not depend on timing.

// File: rtl/bis_pkg.sv
package bis_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_BRK_LO, S_BRK_HI, S_MID, S_WAIT, S_UPDATE, S_DONE
  } state_t;

  typedef enum logic [1:0] {PH_LO, PH_HI, PH_BIS} phase_t;

  typedef enum logic [3:0] {
    OP_HOLD, OP_INIT, OP_DBL_LO, OP_DBL_HI,
    OP_PRB_LO, OP_PRB_HI, OP_PRB_MID, OP_LO_TENT, OP_HI_TENT
  } dp_op_t;
endpackage

// File: rtl/bis_datapath.sv
module bis_datapath
  import bis_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dp_op_t       op,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] tent_q
);
  localparam int         ONE_I   = 1 << FRAC;
  localparam logic [W-1:0] POS_ONE = ONE_I[W-1:0];
  localparam logic [W-1:0] NEG_ONE = -POS_ONE;

  logic [W-1:0] add_a, add_b, dbl, mid;
  logic [W:0]   sum;
  logic [W-1:0] lo_d, hi_d, tent_d;

  // operand selection for the single adder
  assign add_a = (op == OP_DBL_HI) ? hi_q : lo_q;
  assign add_b = (op == OP_DBL_LO) ? lo_q : hi_q;
  assign sum   = {add_a[W-1], add_a} + {add_b[W-1], add_b};
  assign dbl   = sum[W-1:0];
  assign mid   = sum[W:1];   // LSB dropped: floor of the mean

  // write-back selection: constant, adder result or tentative value
  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    tent_d = tent_q;
    unique case (op)
      OP_INIT:    begin lo_d = NEG_ONE; hi_d = POS_ONE; end
      OP_DBL_LO:  lo_d = dbl;
      OP_DBL_HI:  hi_d = dbl;
      OP_LO_TENT: lo_d = tent_q;
      OP_HI_TENT: hi_d = tent_q;
      OP_PRB_LO:  tent_d = lo_q;
      OP_PRB_HI:  tent_d = hi_q;
      OP_PRB_MID: tent_d = mid;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      tent_q <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      tent_q <= tent_d;
    end
  end
endmodule

// File: rtl/bis_width_cmp.sv
module bis_width_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] tol,
  output logic         narrow
);
  localparam logic [W:0] MIN_TOL = (W+1)'(2);

  logic [W:0] width, eff_tol;

  assign width   = {hi[W-1], hi} - {lo[W-1], lo};
  assign eff_tol = ({1'b0, tol} < MIN_TOL) ? MIN_TOL : {1'b0, tol};
  assign narrow  = width < eff_tol;
endmodule

// File: rtl/bis_ctrl.sv
module bis_ctrl
  import bis_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   solve_done,
  input  logic   res_neg,
  input  logic   res_zero,
  input  logic   narrow,
  output dp_op_t op,
  output logic   solve_go,
  output logic   done,
  output logic   err
);
  localparam int EXW = $clog2(MAX_EXP + 1);
  localparam logic [EXW-1:0] EX_LIM = EXW'(MAX_EXP);

  state_t         st_q, st_d;
  phase_t         ph_q, ph_d;
  logic [EXW-1:0] ex_q, ex_d;
  logic           go_d, err_d, neg_q, neg_d, zero_q, zero_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    ex_d   = ex_q;
    op     = OP_HOLD;
    go_d   = 1'b0;
    err_d  = err;
    neg_d  = neg_q;
    zero_d = zero_q;
    unique case (st_q)
      S_IDLE, S_DONE:
        if (start) begin
          op    = OP_INIT;
          ex_d  = '0;
          err_d = 1'b0;
          st_d  = S_BRK_LO;
        end
      S_BRK_LO: begin
        op = OP_PRB_LO; ph_d = PH_LO; go_d = 1'b1; st_d = S_WAIT;
      end
      S_BRK_HI: begin
        op = OP_PRB_HI; ph_d = PH_HI; go_d = 1'b1; st_d = S_WAIT;
      end
      S_MID:
        if (narrow) st_d = S_DONE;
        else begin
          op = OP_PRB_MID; ph_d = PH_BIS; go_d = 1'b1; st_d = S_WAIT;
        end
      S_WAIT:
        if (solve_done) begin
          neg_d  = res_neg;
          zero_d = res_zero;
          st_d   = S_UPDATE;
        end
      S_UPDATE:
        if (zero_q) st_d = S_DONE;
        else begin
          unique case (ph_q)
            PH_LO:
              if (neg_q) st_d = S_BRK_HI;
              else if (ex_q == EX_LIM) begin err_d = 1'b1; st_d = S_DONE; end
              else begin op = OP_DBL_LO; ex_d = ex_q + 1'b1; st_d = S_BRK_LO; end
            PH_HI:
              if (!neg_q) st_d = S_MID;
              else if (ex_q == EX_LIM) begin err_d = 1'b1; st_d = S_DONE; end
              else begin op = OP_DBL_HI; ex_d = ex_q + 1'b1; st_d = S_BRK_HI; end
            default: begin
              op   = neg_q ? OP_LO_TENT : OP_HI_TENT;
              st_d = S_MID;
            end
          endcase
        end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ph_q     <= PH_LO;
      ex_q     <= '0;
      solve_go <= 1'b0;
      err      <= 1'b0;
      neg_q    <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      ex_q     <= ex_d;
      solve_go <= go_d;
      err      <= err_d;
      neg_q    <= neg_d;
      zero_q   <= zero_d;
    end
  end

  assign done = (st_q == S_DONE);
endmodule

// File: rtl/thresh_bisect.sv
module thresh_bisect
  import bis_pkg::*;
#(
  parameter int W       = 16,
  parameter int FRAC    = 4,
  parameter int MAX_EXP = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tol,
  output logic         solve_go,
  input  logic         solve_done,
  input  logic         res_neg,
  input  logic         res_zero,
  output logic [W-1:0] thr_out,
  output logic         done,
  output logic         err
);
  dp_op_t       op;
  logic [W-1:0] lo, hi;
  logic         narrow;

  bis_datapath #(.W(W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rst_n(rst_n), .op(op),
    .lo_q(lo), .hi_q(hi), .tent_q(thr_out)
  );

  bis_width_cmp #(.W(W)) u_cmp (
    .lo(lo), .hi(hi), .tol(tol), .narrow(narrow)
  );

  bis_ctrl #(.MAX_EXP(MAX_EXP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .solve_done(solve_done), .res_neg(res_neg), .res_zero(res_zero),
    .narrow(narrow), .op(op), .solve_go(solve_go), .done(done), .err(err)
  );
endmodule

// File: rtl/thresh_bisect_chk.sv
module thresh_bisect_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         solve_go,
  input logic         solve_done,
  input logic [W-1:0] thr_out,
  input logic         done,
  input logic         err
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= 1'b0;
    else if (solve_go)   pend <= 1'b1;
    else if (solve_done) pend <= 1'b0;
  end

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    solve_go |=> !solve_go);  // R8
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !solve_go);  // R8
  AST_THR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $stable(thr_out));  // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);  // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);  // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !solve_go);  // R6
endmodule

bind thresh_bisect thresh_bisect_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .solve_go(solve_go),
  .solve_done(solve_done), .thr_out(thr_out), .done(done), .err(err)
);

// File: tb/thresh_bisect_tb.sv
module thresh_bisect_tb;
  localparam int CLK_P = 10;
  localparam int MAXE  = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] tol = 16'd2;
  logic solve_go, done, err;
  logic solve_done = 1'b0, res_neg = 1'b0, res_zero = 1'b0;
  logic signed [15:0] thr_out;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  thresh_bisect u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tol(tol),
    .solve_go(solve_go), .solve_done(solve_done), .res_neg(res_neg),
    .res_zero(res_zero), .thr_out(thr_out), .done(done), .err(err)
  );

  // solver stub: residual = probe - target
  int tgt = 0, lat = 0, wcnt = 0, probe_cnt = 0, viol = 0, stab_bad = 0;
  logic pend = 1'b0, go_prev = 1'b0;
  logic signed [15:0] cur = '0;
  logic signed [15:0] plog [0:15];

  always @(posedge clk) begin
    solve_done <= 1'b0;
    if (pend && thr_out != cur) stab_bad++;
    if (solve_go && (pend || go_prev)) viol++;
    go_prev = solve_go;
    if (solve_go) begin
      cur = thr_out;
      plog[probe_cnt % 16] = thr_out;
      probe_cnt++;
      res_neg  <= (int'(thr_out) < tgt);
      res_zero <= (int'(thr_out) == tgt);
      if (lat == 0) begin solve_done <= 1'b1; pend = 1'b0; end
      else begin wcnt = lat; pend = 1'b1; end
    end else if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) begin solve_done <= 1'b1; pend = 1'b0; end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference search from the requirements
  task automatic ref_search(input int target, input int tol_v,
                            output int e_thr, output int e_err, output int e_n);
    int lo = -16, hi = 16, ex = 0, t = 0, et;
    bit fin = 0;
    e_err = 0; e_n = 0;
    et = (tol_v < 2) ? 2 : tol_v;
    while (!fin) begin
      t = lo; e_n++;
      if (t == target) begin e_thr = t; return; end
      if (t < target) fin = 1;
      else if (ex == MAXE) begin e_thr = t; e_err = 1; return; end
      else begin lo = lo * 2; ex++; end
    end
    fin = 0;
    while (!fin) begin
      t = hi; e_n++;
      if (t == target) begin e_thr = t; return; end
      if (t > target) fin = 1;
      else if (ex == MAXE) begin e_thr = t; e_err = 1; return; end
      else begin hi = hi * 2; ex++; end
    end
    while ((hi - lo) >= et) begin
      t = (lo + hi) >>> 1; e_n++;
      if (t == target) break;
      if (t > target) hi = t; else lo = t;
    end
    e_thr = t;
  endtask

  task automatic launch_and_wait(input int target, input int tol_v,
                                 input int l, input bit poke);
    int cyc = 0;
    tgt = target; lat = l; tol = 16'(tol_v);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  task automatic run_case(string req, int target, int tol_v, int l, bit poke);
    int e_thr, e_err, e_n, base;
    base = probe_cnt;
    ref_search(target, tol_v, e_thr, e_err, e_n);
    launch_and_wait(target, tol_v, l, poke);
    check({req, " done"}, int'(done), 1);
    check({req, " thr"}, int'(thr_out), e_thr);
    check({req, " err"}, int'(err), e_err);
    check({req, " probes"}, probe_cnt - base, e_n);
  endtask

  task automatic t_reset();
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
    check("R1 go", int'(solve_go), 0);
    check("R1 thr", int'(thr_out), 0);
  endtask

  task automatic t_bracket_order();
    int base = probe_cnt;
    run_case("R3 hi-double", 37, 4, 3, 0);
    check("R2 first probe", int'(plog[base % 16]), -16);
    check("R2 second probe", int'(plog[(base + 1) % 16]), 16);
    check("R3 hi doubled", int'(plog[(base + 2) % 16]), 32);
    check("R5 first mid", int'(plog[(base + 4) % 16]), 24);
  endtask

  task automatic t_lo_double();
    int base = probe_cnt;
    run_case("R3 lo-double", -100, 2, 0, 0);
    check("R3 lo doubled", int'(plog[(base + 1) % 16]), -32);
  endtask

  task automatic t_bisect();
    run_case("R5 inner", 5, 2, 2, 0);
    run_case("R5 negative", -7, 2, 1, 0);
    run_case("R6 tol0", 7, 0, 5, 0);
  endtask

  task automatic t_zero();
    run_case("R7 first", -16, 2, 1, 0);
    run_case("R7 mid", 0, 2, 2, 0);
  endtask

  task automatic t_limit();
    run_case("R4 high", 5000, 2, 0, 0);
    run_case("R4 low", -5000, 2, 1, 0);
  endtask

  task automatic t_wide_tol();
    run_case("R6 wide", 3, 100, 1, 0);
    check("R6 last probe", int'(thr_out), 16);
  endtask

  task automatic t_sticky();
    run_case("R10 busy-start", 9, 2, 4, 1);
    repeat (6) @(negedge clk);
    check("R10 done held", int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bracket_order();
    t_lo_double();
    t_bisect();
    t_zero();
    t_limit();
    t_wide_tol();
    t_sticky();
    check("R8 launch pulses", viol, 0);
    check("R9 thr stable", stab_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule